// File: doc/BRIEF.md
# Peer Status Broadcast Packet Builder

This block builds a broadcast block-write packet that carries the board's own status block. It sends the packet as a stream of 32-bit quadlets. A query pulse from the host starts one transmission. The block does not answer the query at once: it first waits a number of time slots equal to its node ID. Each board on the bus therefore gets its own turn, in order of node ID, and the boards never collide when they all answer the same query.

The node ID, slot length, sequence number and block size are all captured when the query is accepted. After the wait, the block emits the following quadlets in this order:

1. Five header quadlets. The last of these is an empty slot for the header CRC.
2. A quadlet that holds the sequence number and the block size.
3. The status quadlets, fetched through a synchronous read port.
4. A closing empty slot for the data CRC.

A CRC unit further down the stream fills in both CRC slots. The stream uses a valid/ready handshake with a last marker, and it may be stalled at any quadlet.

Top module: `peer_bcast_tx`

## Requirements
- R1: While reset is held and in the first cycle after it, tx_valid_o and rd_en_o are low.
- R2: The first quadlet becomes valid exactly node_id × slot_cyc + 1 cycles after the clock edge that samples query_i high. A slot_cyc of 0 behaves like 1. With node 0 the first quadlet is valid one cycle after that edge.
- R3: Quadlet 0 is 0xFFFF001A. This encodes destination 0xFFFF in bits 31:16, label and retry zero, transaction code 0x1 in bits 7:4 and peer priority 0xA in bits 3:0.
- R4: Quadlet 1 is {source ID, 0xFFFF}. The source ID is the captured node ID with all upper bits of the 16-bit field set to one. Quadlet 2 is 0xFF001000.
- R5: Quadlet 3 holds the byte count (block size + 1) × 4 in bits 31:16 and extended code 0x0000 in bits 15:0. Quadlet 4, the header CRC slot, is zero.
- R6: Quadlet 5 holds the captured sequence number in bits 31:16 and the captured block size in bits 15:0.
- R7: Status quadlets 0 to block size − 1 follow in address order. The read port returns rd_data_i in the cycle after rd_en_o and holds that value until the next rd_en_o.
- R8: The packet ends with a zero data-CRC quadlet that carries tx_last_o. A packet is always block size + 7 quadlets long, so a block size of 0 gives 7 quadlets.
- R9: While tx_valid_o is high and tx_ready_i is low, the quadlet and last marker are held unchanged. No quadlet is lost or repeated.
- R10: A query that arrives during the slot wait or during transmission is ignored. It starts no second packet and does not change the captured fields.
- R11: rd_en_o is high only in a cycle where a quadlet is accepted (tx_valid_o and tx_ready_i both high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| query_i | input | 1 | Host query pulse |
| node_id_i | input | NODE_W | This board's node ID |
| slot_cyc_i | input | SLOT_W | Slot length in cycles |
| seq_i | input | 16 | Sequence number for the packet |
| blk_quads_i | input | LEN_W | Status block size in quadlets |
| rd_en_o | output | 1 | Status read strobe |
| rd_addr_o | output | LEN_W | Status quadlet address |
| rd_data_i | input | 32 | Status quadlet, one cycle after the strobe |
| tx_valid_o | output | 1 | Output quadlet valid |
| tx_data_o | output | 32 | Output quadlet |
| tx_last_o | output | 1 | Final quadlet of the packet |
| tx_ready_i | input | 1 | Downstream ready |

## Verification
The bench uses the default widths: a 6-bit node ID, a 16-bit slot counter and a 9-bit length. With these widths it can reach node 0 (no wait), node 63 (the largest wait) and a slot length of 0. It also covers block sizes from empty to 20 quadlets. Ready is driven either constantly high or from a pseudo-random pattern. Under the random pattern, stalls land on header, size, status and CRC quadlets alike, which tests the hold rule at every point where the sequence changes state.

// File: rtl/peer_bcast_pkg.sv
package peer_bcast_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_HDR,
        ST_SIZE,
        ST_DATA,
        ST_DCRC
    } pb_state_e;

    localparam logic [15:0] DEST_BCAST  = 16'hFFFF;
    localparam logic [5:0]  TLABEL      = 6'd0;
    localparam logic [1:0]  RETRY_CODE  = 2'd0;
    localparam logic [3:0]  TCODE_BWR   = 4'h1;
    localparam logic [3:0]  PRI_PEER    = 4'hA;
    localparam logic [15:0] OFS_HIGH    = 16'hFFFF;
    localparam logic [31:0] OFS_LOW     = 32'hFF00_1000;
    localparam logic [15:0] EXT_CODE    = 16'h0000;
    localparam logic [31:0] CRC_SLOT    = 32'h0000_0000;
    localparam int          HDR_QUADS   = 5;
    localparam logic [2:0]  HDR_LAST    = 3'(HDR_QUADS - 1);

    function automatic logic [31:0] hdr_word(input logic [2:0]  idx,
                                             input logic [15:0] src_id,
                                             input logic [15:0] byte_len);
        logic [31:0] w;
        case (idx)
            3'd0:    w = {DEST_BCAST, TLABEL, RETRY_CODE, TCODE_BWR, PRI_PEER};
            3'd1:    w = {src_id, OFS_HIGH};
            3'd2:    w = OFS_LOW;
            3'd3:    w = {byte_len, EXT_CODE};
            default: w = CRC_SLOT;
        endcase
        return w;
    endfunction

    function automatic logic [15:0] payload_bytes(input logic [15:0] quads);
        return 16'((quads + 16'd1) << 2);
    endfunction

endpackage

// File: rtl/pbt_slot_timer.sv
module pbt_slot_timer #(
    parameter int NODE_W = 6,
    parameter int SLOT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [NODE_W-1:0] node_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic              done_o
);
    logic              running;
    logic [NODE_W-1:0] slots_left;
    logic [SLOT_W-1:0] cyc_cnt;
    logic [SLOT_W-1:0] slot_len;
    logic [SLOT_W:0]   cyc_next;

    assign cyc_next = {1'b0, cyc_cnt} + 1'b1;
    assign done_o   = running && (slots_left == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            running    <= 1'b0;
            slots_left <= '0;
            cyc_cnt    <= '0;
            slot_len   <= '0;
        end else if (start_i) begin
            running    <= 1'b1;
            slots_left <= node_i;
            cyc_cnt    <= '0;
            slot_len   <= slot_i;
        end else if (running) begin
            if (slots_left == '0) begin
                running <= 1'b0;
            end else if (cyc_next >= {1'b0, slot_len}) begin
                cyc_cnt    <= '0;
                slots_left <= slots_left - 1'b1;
            end else begin
                cyc_cnt <= cyc_next[SLOT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/pbt_frame_seq.sv
module pbt_frame_seq
    import peer_bcast_pkg::*;
#(
    parameter int NODE_W = 6,
    parameter int LEN_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              query_i,
    input  logic [NODE_W-1:0] node_i,
    input  logic [15:0]       seq_i,
    input  logic [LEN_W-1:0]  blk_i,
    input  logic              tmr_done_i,
    input  logic              tx_ready_i,
    output logic              tmr_start_o,
    output pb_state_e         st_o,
    output logic [2:0]        hidx_o,
    output logic [NODE_W-1:0] node_q_o,
    output logic [15:0]       seq_q_o,
    output logic [LEN_W-1:0]  blk_q_o,
    output logic              rd_en_o,
    output logic [LEN_W-1:0]  rd_addr_o
);
    pb_state_e        st;
    logic [2:0]       hidx;
    logic [LEN_W-1:0] didx;
    logic [LEN_W-1:0] blk_q;
    logic             emitting;
    logic             accept;
    logic             data_end;

    assign emitting    = (st == ST_HDR) || (st == ST_SIZE) ||
                         (st == ST_DATA) || (st == ST_DCRC);
    assign accept      = emitting && tx_ready_i;
    assign data_end    = (didx == blk_q - 1'b1);
    assign tmr_start_o = (st == ST_IDLE) && query_i;

    always_comb begin
        rd_en_o   = 1'b0;
        rd_addr_o = '0;
        if (accept && (st == ST_SIZE) && (blk_q != '0)) begin
            rd_en_o = 1'b1;
        end else if (accept && (st == ST_DATA) && !data_end) begin
            rd_en_o   = 1'b1;
            rd_addr_o = didx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            hidx     <= '0;
            didx     <= '0;
            blk_q    <= '0;
            node_q_o <= '0;
            seq_q_o  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (query_i) begin
                    st       <= ST_WAIT;
                    node_q_o <= node_i;
                    seq_q_o  <= seq_i;
                    blk_q    <= blk_i;
                end
                ST_WAIT: if (tmr_done_i) begin
                    st   <= ST_HDR;
                    hidx <= '0;
                end
                ST_HDR: if (accept) begin
                    if (hidx == HDR_LAST) st <= ST_SIZE;
                    else                  hidx <= hidx + 1'b1;
                end
                ST_SIZE: if (accept) begin
                    didx <= '0;
                    st   <= (blk_q == '0) ? ST_DCRC : ST_DATA;
                end
                ST_DATA: if (accept) begin
                    if (data_end) st <= ST_DCRC;
                    else          didx <= didx + 1'b1;
                end
                ST_DCRC: if (accept) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign st_o    = st;
    assign hidx_o  = hidx;
    assign blk_q_o = blk_q;
endmodule

// File: rtl/pbt_word_mux.sv
module pbt_word_mux
    import peer_bcast_pkg::*;
#(
    parameter int NODE_W = 6,
    parameter int LEN_W  = 9
) (
    input  pb_state_e         st_i,
    input  logic [2:0]        hidx_i,
    input  logic [NODE_W-1:0] node_i,
    input  logic [15:0]       seq_i,
    input  logic [LEN_W-1:0]  blk_i,
    input  logic [31:0]       rd_data_i,
    output logic              valid_o,
    output logic [31:0]       data_o,
    output logic              last_o
);
    localparam int PAD_W = 16 - NODE_W;

    logic [15:0] src_id;
    logic [15:0] blk16;

    assign src_id = {{PAD_W{1'b1}}, node_i};
    assign blk16  = 16'(blk_i);

    always_comb begin
        case (st_i)
            ST_HDR:  data_o = hdr_word(hidx_i, src_id, payload_bytes(blk16));
            ST_SIZE: data_o = {seq_i, blk16};
            ST_DATA: data_o = rd_data_i;
            default: data_o = CRC_SLOT;
        endcase
    end

    assign valid_o = (st_i == ST_HDR) || (st_i == ST_SIZE) ||
                     (st_i == ST_DATA) || (st_i == ST_DCRC);
    assign last_o  = (st_i == ST_DCRC);
endmodule

// File: rtl/peer_bcast_tx.sv
module peer_bcast_tx
    import peer_bcast_pkg::*;
#(
    parameter int NODE_W = 6,
    parameter int SLOT_W = 16,
    parameter int LEN_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              query_i,
    input  logic [NODE_W-1:0] node_id_i,
    input  logic [SLOT_W-1:0] slot_cyc_i,
    input  logic [15:0]       seq_i,
    input  logic [LEN_W-1:0]  blk_quads_i,
    output logic              rd_en_o,
    output logic [LEN_W-1:0]  rd_addr_o,
    input  logic [31:0]       rd_data_i,
    output logic              tx_valid_o,
    output logic [31:0]       tx_data_o,
    output logic              tx_last_o,
    input  logic              tx_ready_i
);
    logic              tmr_start;
    logic              tmr_done;
    pb_state_e         st;
    logic [2:0]        hidx;
    logic [NODE_W-1:0] node_q;
    logic [15:0]       seq_q;
    logic [LEN_W-1:0]  blk_q;

    pbt_slot_timer #(.NODE_W(NODE_W), .SLOT_W(SLOT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (tmr_start),
        .node_i  (node_id_i),
        .slot_i  (slot_cyc_i),
        .done_o  (tmr_done)
    );

    pbt_frame_seq #(.NODE_W(NODE_W), .LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .query_i     (query_i),
        .node_i      (node_id_i),
        .seq_i       (seq_i),
        .blk_i       (blk_quads_i),
        .tmr_done_i  (tmr_done),
        .tx_ready_i  (tx_ready_i),
        .tmr_start_o (tmr_start),
        .st_o        (st),
        .hidx_o      (hidx),
        .node_q_o    (node_q),
        .seq_q_o     (seq_q),
        .blk_q_o     (blk_q),
        .rd_en_o     (rd_en_o),
        .rd_addr_o   (rd_addr_o)
    );

    pbt_word_mux #(.NODE_W(NODE_W), .LEN_W(LEN_W)) u_mux (
        .st_i      (st),
        .hidx_i    (hidx),
        .node_i    (node_q),
        .seq_i     (seq_q),
        .blk_i     (blk_q),
        .rd_data_i (rd_data_i),
        .valid_o   (tx_valid_o),
        .data_o    (tx_data_o),
        .last_o    (tx_last_o)
    );
endmodule

// File: rtl/pbt_checker.sv
module pbt_checker (
    input logic        clk,
    input logic        rst,
    input logic        rd_en_o,
    input logic        tx_valid_o,
    input logic [31:0] tx_data_o,
    input logic        tx_last_o,
    input logic        tx_ready_i
);
    // R9: a stalled quadlet stays put
    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));

    // R8: the last marker only travels with a valid quadlet
    a_r8_last_with_valid: assert property (@(posedge clk) disable iff (rst)
        tx_last_o |-> tx_valid_o);

    // R8: nothing follows an accepted last quadlet straight away
    a_r8_gap_after_last: assert property (@(posedge clk) disable iff (rst)
        tx_valid_o && tx_ready_i && tx_last_o |=> !tx_valid_o);

    // R11: reads happen only on a handshake
    a_r11_read_on_accept: assert property (@(posedge clk) disable iff (rst)
        rd_en_o |-> tx_valid_o && tx_ready_i);

    // R3: every packet opens with the fixed peer header quadlet
    a_r3_first_quadlet: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid_o) |-> tx_data_o == 32'hFFFF_001A);
endmodule

bind peer_bcast_tx pbt_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_en_o    (rd_en_o),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .tx_last_o  (tx_last_o),
    .tx_ready_i (tx_ready_i)
);

// File: tb/peer_bcast_tx_tb.sv
module peer_bcast_tx_tb;
    localparam int NODE_W = 6;
    localparam int SLOT_W = 16;
    localparam int LEN_W  = 9;
    localparam int MAXQ   = 600;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              query = 1'b0;
    logic [NODE_W-1:0] node = '0;
    logic [SLOT_W-1:0] slot = '0;
    logic [15:0]       seq = '0;
    logic [LEN_W-1:0]  blk = '0;
    logic              rd_en;
    logic [LEN_W-1:0]  rd_addr;
    logic [31:0]       rd_data = '0;
    logic              tx_valid;
    logic [31:0]       tx_data;
    logic              tx_last;
    logic              tx_ready = 1'b1;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rmode  = 0;
    int got_n  = 0;
    int first_cyc = -1;
    int bad_reads = 0;
    logic        pv = 1'b0;
    logic [31:0] got_d [MAXQ];
    logic        got_l [MAXQ];
    logic [15:0] lfsr = 16'hACE1;

    peer_bcast_tx #(.NODE_W(NODE_W), .SLOT_W(SLOT_W), .LEN_W(LEN_W)) u_dut (
        .clk (clk), .rst (rst), .query_i (query), .node_id_i (node),
        .slot_cyc_i (slot), .seq_i (seq), .blk_quads_i (blk),
        .rd_en_o (rd_en), .rd_addr_o (rd_addr), .rd_data_i (rd_data),
        .tx_valid_o (tx_valid), .tx_data_o (tx_data), .tx_last_o (tx_last),
        .tx_ready_i (tx_ready)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] memval(input int a);
        return {8'hC3, 8'(a), 16'(a * 7 + 3)};
    endfunction

    function automatic logic [31:0] exp_word(input int i, input int n, input int s, input int b);
        if (i == 0) return 32'hFFFF_001A;
        if (i == 1) return {10'h3FF, 6'(n), 16'hFFFF};
        if (i == 2) return 32'hFF00_1000;
        if (i == 3) return {16'((b + 1) * 4), 16'h0000};
        if (i == 4) return 32'h0;
        if (i == 5) return {16'(s), 16'(b)};
        if (i < b + 6) return memval(i - 6);
        return 32'h0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model and ready pattern
    initial forever begin
        @(posedge clk);
        if (rd_en) rd_data <= memval(int'(rd_addr));
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready <= (rmode == 0) ? 1'b1 : (lfsr[0] | lfsr[5]);
    end

    // monitor away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (tx_valid && !pv && first_cyc < 0) first_cyc = cyc;
            if (tx_valid && tx_ready && got_n < MAXQ) begin
                got_d[got_n] = tx_data;
                got_l[got_n] = tx_last;
                got_n++;
            end
            if (rd_en && !(tx_valid && tx_ready)) bad_reads++;
        end
        pv = tx_valid;
    end

    task automatic pulse_query();
        @(posedge clk); query <= 1'b1;
        @(posedge clk); query <= 1'b0;
    endtask

    task automatic run_packet(input int n, input int s, input int sq, input int b, input int rm, input bit extra);
        int qcyc;
        int d;
        int tmo;
        d = n * ((s == 0) ? 1 : s);
        rmode = rm;
        got_n = 0;
        first_cyc = -1;
        @(posedge clk);
        node <= NODE_W'(n); slot <= SLOT_W'(s); seq <= 16'(sq); blk <= LEN_W'(b);
        pulse_query();
        @(negedge clk); qcyc = cyc;
        if (extra) begin
            // R10: query during the wait with different fields
            @(posedge clk);
            node <= NODE_W'(n + 1); seq <= 16'(sq + 1); blk <= LEN_W'(b + 2);
            pulse_query();
        end
        tmo = 0;
        while (got_n < 3 && tmo < d + 2000) begin @(negedge clk); tmo++; end
        if (extra) begin
            // R10: query during transmission
            @(posedge clk); node <= '0;
            pulse_query();
        end
        tmo = 0;
        while (got_n < b + 7 && tmo < d + 5000) begin @(negedge clk); tmo++; end
        check(first_cyc == qcyc + 1 + d, "R2 start slot", 32'(first_cyc - qcyc), 32'(1 + d));
        for (int i = 0; i < b + 7; i++) begin
            string r;
            r = (i == 0) ? "R3 word0" : (i < 3) ? "R4 addr words" : (i < 5) ? "R5 len/hcrc" :
                (i == 5) ? "R6 seq/size" : (i < b + 6) ? "R7 status" : "R8 data crc";
            check(got_d[i] === exp_word(i, n, sq, b), r, got_d[i], exp_word(i, n, sq, b));
            check(got_l[i] === (i == b + 6), "R8 last flag", 32'(got_l[i]), 32'(i == b + 6));
        end
        repeat (extra ? d + 200 : 40) @(negedge clk);
        check(got_n == b + 7, extra ? "R10 no second packet" : "R8 packet length", 32'(got_n), 32'(b + 7));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(tx_valid === 1'b0, "R1 valid in reset", 32'(tx_valid), 0);
        check(rd_en === 1'b0, "R1 read in reset", 32'(rd_en), 0);
        @(posedge clk); rst <= 1'b0;
        @(negedge clk);
        check(tx_valid === 1'b0 && rd_en === 1'b0, "R1 after reset", 32'({tx_valid, rd_en}), 0);
    endtask

    task automatic t_stall_hold();
        // R9: with random ready the content above must arrive intact; also rd strobes
        check(bad_reads == 0, "R11 read only on accept", 32'(bad_reads), 0);
    endtask

    initial begin
        t_reset();
        run_packet(0, 5, 16'h1234, 4, 0, 1'b0);   // R2 node 0
        run_packet(3, 10, 16'hBEEF, 6, 1, 1'b0);  // R9 stalls
        run_packet(2, 0, 16'h0007, 0, 0, 1'b0);   // R2 slot 0, R8 empty block
        run_packet(5, 7, 16'h4242, 3, 1, 1'b1);   // R10 ignored queries
        run_packet(63, 3, 16'hFFFF, 20, 1, 1'b0); // R2 max node, R9
        t_stall_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired at cycle %0d expected finish earlier", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule